// File: doc/BRIEF.md
# Register Operate Execution Unit

This unit carries out the three register-to-register operate instructions of a small 16-bit load/store processor: addition, bitwise AND and bitwise complement. Each cycle it can accept one 16-bit instruction word, qualified by a valid strobe. It reads up to two source registers from an internal eight-entry register file, computes the result, and writes the result back on the following clock edge. The same edge updates a one-hot negative/zero/positive flag triple that describes the written value.

The result, its destination index and the flags are presented on registered outputs. A surrounding control path can use these outputs to follow every write-back. Encodings that carry one of the three operate opcodes but fill their reserved bits wrongly are rejected: they write nothing and raise a one-cycle illegal pulse. Any other opcode passes through with no effect. Loads, stores, branches and fetch sequencing belong to other blocks.

Top module: `opx_unit`

## Requirements
- R1: After synchronous reset, every register holds zero, flag_z is 1, flag_n and flag_p are 0, and res_valid and illegal are 0.
- R2: Opcode 0001 in bits 15:12 with bit 5 = 0 and bits 4:3 = 00 writes the sum of the register at bits 8:6 and the register at bits 2:0 to the register at bits 11:9. The sum wraps modulo 2^16 and has no carry output.
- R3: Opcode 0001 with bit 5 = 1 adds the register at bits 8:6 to bits 4:0. Bits 4:0 are sign-extended to 16 bits before the addition.
- R4: Opcode 0101 performs bitwise AND. The operand choice is the same as for R2 and R3: a second register when bit 5 = 0, a sign-extended 5-bit immediate when bit 5 = 1.
- R5: Opcode 1001 with bits 5:0 = 111111 writes the bitwise complement of the register at bits 8:6 to the register at bits 11:9.
- R6: An instruction accepted at a clock edge has its result on res_data, and its destination index on res_dest, with res_valid = 1, after that edge. The next accepted instruction already reads the updated register.
- R7: Every write sets exactly one flag: flag_n when result bit 15 is 1, flag_z when the result is zero, and flag_p otherwise. Cycles without a write leave the flags unchanged.
- R8: An instruction whose opcode is not 0001, 0101 or 1001 writes no register, leaves the flags unchanged, and raises neither res_valid nor illegal.
- R9: An ADD or AND with bit 5 = 0 and bits 4:3 not 00, or a NOT with bits 5:0 not all ones, writes nothing and leaves the flags unchanged. It also sets illegal to 1 for exactly one cycle after the accepting edge.
- R10: A source register may also be the destination. The operation then uses the value from before the write.
- R11: While instr_valid is 0, the instruction word has no effect on registers, flags, res_valid or illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| res_valid | output | 1 | A register was written at the last edge |
| res_dest | output | 3 | Index of the register written |
| res_data | output | 16 | Value written |
| flag_n | output | 1 | Last written value was negative |
| flag_z | output | 1 | Last written value was zero |
| flag_p | output | 1 | Last written value was positive |
| illegal | output | 1 | One-cycle pulse for a malformed operate encoding |

## Verification
The immediate-mode sweep crosses all destinations and first sources with all 32 immediates. This covers sign extension of both negative and positive immediates, and it also covers wrap-around as the register values grow. The register-mode sweeps cross all destination and source triples for ADD and AND, so aliased sources and destinations are exercised. A full NOT sweep separates complement from the other two operations. All 13 foreign opcodes, malformed reserved-bit patterns and idle cycles with an operate word on the bus are each followed by register read-back. These prove that state was left untouched and that the illegal pulse lasts one cycle.

// File: rtl/opx_pkg.sv
package opx_pkg;
  localparam int INSTR_W = 16;
  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;
  localparam int IMM_W = 5;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_AND = 2'd1,
    ALU_NOT = 2'd2
  } alu_op_e;
endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic               valid,
  output alu_op_e            alu_op,
  output logic [2:0]         dst,
  output logic [2:0]         src1,
  output logic [2:0]         src2,
  output logic               use_imm,
  output logic [IMM_W-1:0]   imm,
  output logic               wr_en,
  output logic               bad
);
  logic [3:0] opc;
  logic       is_add, is_and, is_not, is_oper, legal;

  always_comb begin
    opc     = instr[15:12];
    is_add  = (opc == OPC_ADD);
    is_and  = (opc == OPC_AND);
    is_not  = (opc == OPC_NOT);
    is_oper = is_add | is_and | is_not;
    legal   = is_not ? (instr[5:0] == 6'h3F)
                     : (instr[5] | (instr[4:3] == 2'b00));
    wr_en   = valid & is_oper & legal;
    bad     = valid & is_oper & ~legal;
    if (is_and)      alu_op = ALU_AND;
    else if (is_not) alu_op = ALU_NOT;
    else             alu_op = ALU_ADD;
    dst     = instr[11:9];
    src1    = instr[8:6];
    src2    = instr[2:0];
    use_imm = instr[5] & ~is_not;
    imm     = instr[IMM_W-1:0];
  end
endmodule

// File: rtl/opx_regfile.sv
module opx_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/opx_alu.sv
module opx_alu
  import opx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_NOT: y = ~a;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/opx_unit.sv
module opx_unit
  import opx_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  localparam int RA_W   = $clog2(REG_CNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  output logic               res_valid,
  output logic [RA_W-1:0]    res_dest,
  output logic [DATA_W-1:0]  res_data,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_p,
  output logic               illegal
);
  alu_op_e           alu_op;
  logic [2:0]        dst, src1, src2;
  logic              use_imm, wr_en, bad;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] rd_a, rd_b, opnd_b, imm_ext, result;

  opx_decode u_dec (
    .instr   (instr),
    .valid   (instr_valid),
    .alu_op  (alu_op),
    .dst     (dst),
    .src1    (src1),
    .src2    (src2),
    .use_imm (use_imm),
    .imm     (imm),
    .wr_en   (wr_en),
    .bad     (bad)
  );

  opx_regfile #(.DATA_W(DATA_W), .DEPTH(REG_CNT)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (dst[RA_W-1:0]),
    .wdata   (result),
    .raddr_a (src1[RA_W-1:0]),
    .raddr_b (src2[RA_W-1:0]),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign opnd_b  = use_imm ? imm_ext : rd_b;

  opx_alu #(.DATA_W(DATA_W)) u_alu (
    .op (alu_op),
    .a  (rd_a),
    .b  (opnd_b),
    .y  (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_dest  <= '0;
      res_data  <= '0;
      illegal   <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b1;
      flag_p    <= 1'b0;
    end else begin
      res_valid <= wr_en;
      illegal   <= bad;
      if (wr_en) begin
        res_dest <= dst[RA_W-1:0];
        res_data <= result;
        flag_n   <= result[DATA_W-1];
        flag_z   <= (result == '0);
        flag_p   <= ~result[DATA_W-1] & (result != '0);
      end
    end
  end

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones({flag_n, flag_z, flag_p}) == 1); // R7
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (flag_z == (res_data == '0))); // R7
  AST_NEG_MATCH: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (flag_n == res_data[DATA_W-1])); // R7
  AST_ILL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !res_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!res_valid && !illegal && $stable({flag_n, flag_z, flag_p}))); // R11
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr[15:12] != OPC_ADD && instr[15:12] != OPC_AND
     && instr[15:12] != OPC_NOT) |=> (!res_valid && !illegal)); // R8
endmodule

// File: tb/opx_unit_test.sv
`timescale 1ns/1ps
module opx_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        res_valid, flag_n, flag_z, flag_p, illegal;
  logic [2:0]  res_dest;
  logic [15:0] res_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] m_rf [8];
  logic        m_n, m_z, m_p;

  always #2 clk = ~clk;

  opx_unit uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .res_valid(res_valid), .res_dest(res_dest), .res_data(res_data),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic exec(input logic [15:0] ins, input string req);
    logic [3:0]  op;
    logic [15:0] a, b, r;
    logic [31:0] act, exp;
    int kind;
    op = ins[15:12];
    a  = m_rf[ins[8:6]];
    b  = ins[5] ? {{11{ins[4]}}, ins[4:0]} : m_rf[ins[2:0]];
    kind = 0;
    if (op == 4'b0001 || op == 4'b0101) kind = (ins[5] || ins[4:3] == 2'b00) ? 1 : 2;
    else if (op == 4'b1001) kind = (ins[5:0] == 6'h3F) ? 1 : 2;
    r = (op == 4'b0001) ? a + b : (op == 4'b0101) ? (a & b) : ~a;
    @(negedge clk);
    instr = ins;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    if (kind == 1) begin
      m_rf[ins[11:9]] = r;
      m_n = r[15];
      m_z = (r == 16'h0);
      m_p = !r[15] && (r != 16'h0);
      exp = {8'h0, 1'b1, 1'b0, m_n, m_z, m_p, ins[11:9], r};
      act = {8'h0, res_valid, illegal, flag_n, flag_z, flag_p, res_dest, res_data};
    end else begin
      exp = {8'h0, 1'b0, (kind == 2), m_n, m_z, m_p, 19'h0};
      act = {8'h0, res_valid, illegal, flag_n, flag_z, flag_p, 19'h0};
    end
    chk(act == exp, req, act, exp);
  endtask

  task automatic idle_chk(input logic [15:0] ins, input string req);
    logic [31:0] act, exp;
    @(negedge clk);
    instr = ins;
    instr_valid = 1'b0;
    @(negedge clk);
    exp = {27'h0, 1'b0, 1'b0, m_n, m_z, m_p};
    act = {27'h0, res_valid, illegal, flag_n, flag_z, flag_p};
    chk(act == exp, req, act, exp);
  endtask

  task automatic readback(input logic [2:0] r, input string req);
    exec({4'b0001, r, r, 1'b1, 5'd0}, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R6 act=timeout exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_rf[i] = 16'h0;
    m_n = 1'b0; m_z = 1'b1; m_p = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    chk({res_valid, illegal, flag_n, flag_z, flag_p} == 5'b00010, "R1 reset outputs",
        {27'h0, res_valid, illegal, flag_n, flag_z, flag_p}, 32'h2);
    for (int r = 0; r < 8; r++) readback(3'(r), "R1 reset register zero");

    // R3 / R6 / R10: ADD immediate sweep over destination, source, immediate
    for (int d = 0; d < 8; d++)
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 32; k++)
          exec({4'b0001, 3'(d), 3'(s), 1'b1, 5'(k)}, "R3 add imm R6 R10");

    // R2: ADD register sweep, includes aliasing and wrap
    for (int d = 0; d < 8; d++)
      for (int s = 0; s < 8; s++)
        for (int t = 0; t < 8; t++)
          exec({4'b0001, 3'(d), 3'(s), 3'b000, 3'(t)}, "R2 add reg R10");

    // R5: NOT sweep
    for (int d = 0; d < 8; d++)
      for (int s = 0; s < 8; s++)
        exec({4'b1001, 3'(d), 3'(s), 6'h3F}, "R5 not");

    // R4: AND register sweep
    for (int d = 0; d < 8; d++)
      for (int s = 0; s < 8; s++)
        for (int t = 0; t < 8; t++) begin
          exec({4'b1001, 3'(t), 3'(t), 6'h3F}, "R5 not refill");
          exec({4'b0101, 3'(d), 3'(s), 3'b000, 3'(t)}, "R4 and reg");
        end

    // R4: AND immediate sweep
    for (int d = 0; d < 8; d++)
      for (int k = 0; k < 32; k++) begin
        exec({4'b1001, 3'((d + 1) % 8), 3'(d), 6'h3F}, "R5 not refill");
        exec({4'b0101, 3'(d), 3'((d + 1) % 8), 1'b1, 5'(k)}, "R4 and imm");
      end

    // R8: foreign opcodes
    for (int o = 0; o < 16; o++) begin
      if (o != 1 && o != 5 && o != 9) begin
        exec({4'(o), 12'hA7F}, "R8 foreign opcode");
        readback(3'd5, "R8 register untouched");
      end
    end

    // R9: malformed operate encodings
    for (int m = 1; m < 4; m++) begin
      exec({4'b0001, 3'd2, 3'd3, 1'b0, 2'(m), 3'd4}, "R9 add bad bits");
      idle_chk(16'h0, "R9 illegal one cycle");
      readback(3'd2, "R9 add dest untouched");
      exec({4'b0101, 3'd6, 3'd1, 1'b0, 2'(m), 3'd0}, "R9 and bad bits");
      idle_chk(16'h0, "R9 illegal one cycle");
      readback(3'd6, "R9 and dest untouched");
    end
    for (int m = 0; m < 63; m++) begin
      exec({4'b1001, 3'd7, 3'd0, 6'(m)}, "R9 not bad bits");
      readback(3'd7, "R9 not dest untouched");
    end

    // R11: operate word on the bus without valid
    for (int d = 0; d < 8; d++) begin
      idle_chk({4'b0001, 3'(d), 3'(d), 1'b1, 5'd9}, "R11 no valid");
      readback(3'(d), "R11 register untouched");
    end

    // R7: explicit flag polarities
    exec({4'b0101, 3'd0, 3'd0, 1'b1, 5'd0}, "R7 zero");
    exec({4'b0001, 3'd0, 3'd0, 1'b1, 5'h10}, "R7 negative");
    exec({4'b0001, 3'd1, 3'd0, 1'b1, 5'd0}, "R7 negative copy");
    exec({4'b1001, 3'd0, 3'd0, 6'h3F}, "R7 positive");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule